// File: doc/BRIEF.md
# Binary Tape Image Loader

This block turns a stream of 8-bit tape frames, written in the binary punch format of a 12-bit machine, into word writes to a memory with 15-bit word addresses. Each data word arrives as two 6-bit halves. The stream can also carry frames that change the load address, frames that select one of eight 4K-word fields, and a checksum at the end. A host pulses `start_i` and then presents one frame per cycle on a valid/data pair. The block drives a single registered write port and raises `done_o` when it reaches the end mark. At that point `csum_err_o` shows whether the checksum agreed. `ovf_o` reports any word that was aimed past the end of the memory.

The block holds at most one frame of look-ahead. A word is known to be complete only when the first frame of the following word arrives, so each write is issued one frame late. A field selection takes effect at that same point.

Top module: `bin_tape_loader`

## Requirements
- R1: After reset, and in the cycle after any `start_i` pulse, `done_o`, `csum_err_o`, `ovf_o` and `wr_en_o` are low. The running sum, field and load address are zero, so a data word with no address frame before it is written to address 0.
- R2: Before the first word, frames of value 0 or octal 200 are skipped without any effect.
- R3: A word is formed as (first frame << 6) | second frame. A data word is written when the first frame of the next item arrives, and `wr_en_o`, `wr_addr_o` and `wr_data_o` are valid in the cycle after that frame is accepted.
- R4: A word whose bit 12 is set (first frame bit 6 set) loads its low 12 bits as the new load address and causes no write.
- R5: A data word is written at {field, load address}. The load address then increments modulo 4096, so address 07777 wraps to 0 within the same field.
- R6: A frame of octal 377 is dropped, and so is the frame after it, whatever its value, including another 377 or a field frame.
- R7: A frame above octal 200 that is not dropped selects the field from its bits 5:3, which become address bits 14:12. The new field applies from the word that completes after the one in progress.
- R8: A frame of octal 200 in the position of a word's first frame ends the load. `done_o` rises in the next cycle and holds until `start_i`, and frames accepted while done have no effect.
- R9: The sum, modulo 4096, of both frames of every word except the last one is compared with that last word. `csum_err_o` rises together with `done_o` when the two differ.
- R10: A data word whose address is MEM_WORDS or more is not written and sets the sticky `ovf_o`. The load address still advances.
- R11: When `start_i` and `byte_vld_i` are high in the same cycle, the clear wins and that frame is dropped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Clears the engine for a new load |
| byte_vld_i | input | 1 | A frame is present on `byte_i` |
| byte_i | input | 8 | Tape frame |
| wr_en_o | output | 1 | Memory write strobe, one cycle |
| wr_addr_o | output | 15 | Word address {field, load address} |
| wr_data_o | output | 12 | Word to store |
| done_o | output | 1 | End mark seen |
| csum_err_o | output | 1 | Checksum mismatch at end |
| ovf_o | output | 1 | A word was aimed beyond the memory |

## Verification
The assertions rely on `start_i` being a single-cycle pulse. They also rely on every frame being held for exactly one accepted cycle, so each write pulse can be traced to one accepted frame. The stimulus keeps to this: frames are driven one per cycle, sometimes with idle cycles between them, start pulses last one cycle, and only one start deliberately coincides with a valid frame. The memory limit for the run is set to half the address space, so both the last in-range word and the fields beyond it occur.

// File: rtl/btl_pkg.sv
package btl_pkg;

    // Progress through one load.
    typedef enum logic [1:0] {
        PH_LEAD = 2'd0,  // waiting for the first non-leader frame
        PH_LOW  = 2'd1,  // first half held, second half expected
        PH_NEXT = 2'd2,  // a full word held, next first half or end mark expected
        PH_DONE = 2'd3   // end mark seen
    } phase_e;

endpackage

// File: rtl/btl_frame_class.sv
module btl_frame_class #(
    parameter  int HALF_W  = 6,
    parameter  int FIELD_W = 3,
    localparam int FRAME_W = HALF_W + 2,
    localparam int FLD_LSB = HALF_W / 2
) (
    input  logic [FRAME_W-1:0] frame_i,
    output logic               rub_o,
    output logic               mark_o,
    output logic               blank_o,
    output logic               field_o,
    output logic [FIELD_W-1:0] fval_o
);

    always_comb begin
        rub_o   = &frame_i;
        blank_o = (frame_i == '0);
        mark_o  = frame_i[FRAME_W-1] && (frame_i[FRAME_W-2:0] == '0);
        field_o = frame_i[FRAME_W-1] && !mark_o && !rub_o;
        fval_o  = frame_i[FLD_LSB +: FIELD_W];
    end

endmodule

// File: rtl/btl_word_unit.sv
module btl_word_unit #(
    parameter  int WORD_W    = 12,
    parameter  int FIELD_W   = 3,
    parameter  int MEM_WORDS = 1 << (WORD_W + FIELD_W),
    localparam int HALF_W    = WORD_W / 2,
    localparam int FRAME_W   = HALF_W + 2,
    localparam int ADDR_W    = WORD_W + FIELD_W
) (
    input  logic [HALF_W:0]    hi_i,
    input  logic [FRAME_W-1:0] lo_i,
    input  logic [WORD_W-1:0]  sum_i,
    input  logic [WORD_W-1:0]  origin_i,
    input  logic [FIELD_W-1:0] field_i,
    output logic [WORD_W:0]    word_o,
    output logic [ADDR_W-1:0]  addr_o,
    output logic               in_range_o,
    output logic [WORD_W-1:0]  sum_next_o,
    output logic [WORD_W-1:0]  origin_next_o,
    output logic               cs_bad_o
);

    localparam logic [ADDR_W:0] LIMIT = (ADDR_W + 1)'(MEM_WORDS);

    always_comb begin
        word_o        = {hi_i, {HALF_W{1'b0}}} | (WORD_W + 1)'(lo_i);
        addr_o        = {field_i, origin_i};
        in_range_o    = {1'b0, addr_o} < LIMIT;
        sum_next_o    = sum_i + WORD_W'(hi_i) + WORD_W'(lo_i);
        origin_next_o = origin_i + WORD_W'(1);
        cs_bad_o      = (sum_i - word_o[WORD_W-1:0]) != '0;
    end

endmodule

// File: rtl/bin_tape_loader.sv
module bin_tape_loader
    import btl_pkg::*;
#(
    parameter  int WORD_W    = 12,
    parameter  int FIELD_W   = 3,
    parameter  int MEM_WORDS = 1 << (WORD_W + FIELD_W),
    localparam int HALF_W    = WORD_W / 2,
    localparam int FRAME_W   = HALF_W + 2,
    localparam int ADDR_W    = WORD_W + FIELD_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start_i,
    input  logic               byte_vld_i,
    input  logic [FRAME_W-1:0] byte_i,
    output logic               wr_en_o,
    output logic [ADDR_W-1:0]  wr_addr_o,
    output logic [WORD_W-1:0]  wr_data_o,
    output logic               done_o,
    output logic               csum_err_o,
    output logic               ovf_o
);

    typedef struct packed {
        phase_e              phase;
        logic                skip;
        logic [HALF_W:0]     hi;
        logic [FRAME_W-1:0]  lo;
        logic [WORD_W-1:0]   sum;
        logic [WORD_W-1:0]   origin;
        logic [FIELD_W-1:0]  field;
        logic [FIELD_W-1:0]  nfield;
        logic                wr_en;
        logic [ADDR_W-1:0]   wr_addr;
        logic [WORD_W-1:0]   wr_data;
        logic                done;
        logic                cerr;
        logic                ovf;
    } state_t;

    state_t st_q, st_d;

    logic               is_rub, is_mark, is_blank, is_fld;
    logic [FIELD_W-1:0] fval;

    logic [WORD_W:0]    word;
    logic [ADDR_W-1:0]  waddr;
    logic               in_range;
    logic [WORD_W-1:0]  sum_next;
    logic [WORD_W-1:0]  origin_next;
    logic               cs_bad;

    btl_frame_class #(
        .HALF_W  (HALF_W),
        .FIELD_W (FIELD_W)
    ) u_class (
        .frame_i (byte_i),
        .rub_o   (is_rub),
        .mark_o  (is_mark),
        .blank_o (is_blank),
        .field_o (is_fld),
        .fval_o  (fval)
    );

    btl_word_unit #(
        .WORD_W    (WORD_W),
        .FIELD_W   (FIELD_W),
        .MEM_WORDS (MEM_WORDS)
    ) u_word (
        .hi_i          (st_q.hi),
        .lo_i          (st_q.lo),
        .sum_i         (st_q.sum),
        .origin_i      (st_q.origin),
        .field_i       (st_q.field),
        .word_o        (word),
        .addr_o        (waddr),
        .in_range_o    (in_range),
        .sum_next_o    (sum_next),
        .origin_next_o (origin_next),
        .cs_bad_o      (cs_bad)
    );

    always_comb begin
        st_d       = st_q;
        st_d.wr_en = 1'b0;
        if (start_i) begin
            st_d = '0;
        end else if (byte_vld_i && st_q.phase != PH_DONE) begin
            if (st_q.skip) begin
                // second frame of a dropped pair
                st_d.skip = 1'b0;
            end else if (is_rub) begin
                st_d.skip = 1'b1;
            end else if (is_fld) begin
                // held until the word in progress completes
                st_d.nfield = fval;
            end else begin
                unique case (st_q.phase)
                    PH_LEAD: begin
                        if (!is_blank && !is_mark) begin
                            st_d.hi    = byte_i[HALF_W:0];
                            st_d.phase = PH_LOW;
                        end
                    end
                    PH_LOW: begin
                        st_d.lo    = byte_i;
                        st_d.phase = PH_NEXT;
                    end
                    PH_NEXT: begin
                        if (is_mark) begin
                            st_d.done  = 1'b1;
                            st_d.cerr  = cs_bad;
                            st_d.phase = PH_DONE;
                        end else begin
                            st_d.sum = sum_next;
                            if (word[WORD_W]) begin
                                st_d.origin = word[WORD_W-1:0];
                            end else begin
                                if (in_range) begin
                                    st_d.wr_en   = 1'b1;
                                    st_d.wr_addr = waddr;
                                    st_d.wr_data = word[WORD_W-1:0];
                                end else begin
                                    st_d.ovf = 1'b1;
                                end
                                st_d.origin = origin_next;
                            end
                            st_d.field = st_q.nfield;
                            st_d.hi    = byte_i[HALF_W:0];
                            st_d.phase = PH_LOW;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign wr_en_o    = st_q.wr_en;
    assign wr_addr_o  = st_q.wr_addr;
    assign wr_data_o  = st_q.wr_data;
    assign done_o     = st_q.done;
    assign csum_err_o = st_q.cerr;
    assign ovf_o      = st_q.ovf;

endmodule

// File: rtl/btl_loader_chk.sv
module btl_loader_chk #(
    parameter int ADDR_W    = 15,
    parameter int MEM_WORDS = 1 << 15
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start_i,
    input logic              byte_vld_i,
    input logic              wr_en_o,
    input logic [ADDR_W-1:0] wr_addr_o,
    input logic              done_o,
    input logic              csum_err_o,
    input logic              ovf_o
);

    localparam logic [ADDR_W:0] LIMIT = (ADDR_W + 1)'(MEM_WORDS);

    // R10
    wr_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_o |-> ({1'b0, wr_addr_o} < LIMIT));

    // R10
    ovf_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_o && !start_i |=> ovf_o);

    // R8
    done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o && !start_i |=> done_o);

    // R8
    done_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !wr_en_o);

    // R1
    start_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> !done_o && !csum_err_o && !ovf_o && !wr_en_o);

    // R9
    cerr_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        csum_err_o |-> done_o);

    // R3
    wr_from_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_o |-> $past(byte_vld_i) && !$past(start_i));

endmodule

bind bin_tape_loader btl_loader_chk #(
    .ADDR_W    (ADDR_W),
    .MEM_WORDS (MEM_WORDS)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_i),
    .byte_vld_i (byte_vld_i),
    .wr_en_o    (wr_en_o),
    .wr_addr_o  (wr_addr_o),
    .done_o     (done_o),
    .csum_err_o (csum_err_o),
    .ovf_o      (ovf_o)
);

// File: tb/sim_bin_tape_loader.sv
module sim_bin_tape_loader;

    localparam int MEMW = 16384;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        vld = 1'b0;
    logic [7:0]  bt = 8'd0;
    logic        wr_en;
    logic [14:0] wr_addr;
    logic [11:0] wr_data;
    logic        done, cerr, ovf;

    always #4 clk = ~clk;

    bin_tape_loader #(.MEM_WORDS(MEMW)) u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start),
        .byte_vld_i (vld),
        .byte_i     (bt),
        .wr_en_o    (wr_en),
        .wr_addr_o  (wr_addr),
        .wr_data_o  (wr_data),
        .done_o     (done),
        .csum_err_o (cerr),
        .ovf_o      (ovf)
    );

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    logic [7:0] tape [0:1023];
    int tlen;
    int esum;
    int wa [0:255];
    int wd [0:255];
    int wcnt = 0;

    // write log, sampled 2 ns after each rising edge
    always begin
        @(posedge clk);
        #2;
        if (wr_en) begin
            if (wcnt < 256) begin
                wa[wcnt] = int'(wr_addr);
                wd[wcnt] = int'(wr_data);
            end
            wcnt++;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0o expected %0o", req, act, exp);
        end
    endtask

    task automatic t_clear();
        tlen = 0;
        esum = 0;
    endtask

    task automatic t_byte(input int b);
        tape[tlen] = 8'(b);
        tlen++;
    endtask

    task automatic t_word(input int w);
        t_byte((w >> 6) & 'o177);
        t_byte(w & 'o77);
        esum = (esum + ((w >> 6) & 'o177) + (w & 'o77)) & 'o7777;
    endtask

    task automatic t_trailer(input int bad);
        int cs;
        cs = (esum + bad) & 'o7777;
        t_byte((cs >> 6) & 'o77);
        t_byte(cs & 'o77);
        t_byte('o200);
    endtask

    task automatic feed(input bit gaps);
        for (int i = 0; i < tlen; i++) begin
            @(negedge clk);
            vld = 1'b1;
            bt  = tape[i];
            if (gaps && (i % 3 == 2)) begin
                @(negedge clk);
                vld = 1'b0;
            end
        end
        @(negedge clk);
        vld = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic do_start(input bit with_byte);
        @(negedge clk);
        start = 1'b1;
        vld   = with_byte;
        bt    = 8'o001;
        @(negedge clk);
        start = 1'b0;
        vld   = 1'b0;
        wcnt  = 0;
    endtask

    task automatic exp_wr(input string req, input int idx, input int addr, input int data);
        if (idx < wcnt) begin
            chk(req, wa[idx], addr);
            chk(req, wd[idx], data);
        end else begin
            chk(req, wcnt, idx + 1);
        end
    endtask

    task automatic build_main(input int bad);
        t_clear();
        t_byte('o200); t_byte('o200); t_byte(0); t_byte(0); t_byte('o200);
        t_word('o10200);
        t_word('o1234);
        t_word('o7777);
        t_word('o0001);
        t_byte('o230);
        t_byte('o377);
        t_byte('o123);
        t_word('o4321);
        t_word('o17776);
        t_word('o0055);
        t_word('o0066);
        t_word('o0077);
        t_trailer(bad);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1 done after reset", int'(done), 0);
        chk("R1 cerr after reset", int'(cerr), 0);
        chk("R1 ovf after reset", int'(ovf), 0);
        chk("R1 wr_en after reset", int'(wr_en), 0);

        // main tape: leader, origin, field, rubout pair, wrap
        do_start(1'b0);
        build_main(0);
        feed(1'b0);
        chk("R3 write count", wcnt, 7);
        exp_wr("R4 R3 first word at origin", 0, 'o00200, 'o1234);
        exp_wr("R5 next address", 1, 'o00201, 'o7777);
        exp_wr("R7 field deferred", 2, 'o00202, 'o0001);
        exp_wr("R6 R7 after rubout in new field", 3, 'o30203, 'o4321);
        exp_wr("R4 origin in field", 4, 'o37776, 'o0055);
        exp_wr("R10 last in-range word", 5, 'o37777, 'o0066);
        exp_wr("R5 origin wrap", 6, 'o30000, 'o0077);
        chk("R8 done", int'(done), 1);
        chk("R9 good checksum", int'(cerr), 0);
        chk("R10 no ovf", int'(ovf), 0);

        // R8 frames after done are ignored
        t_clear();
        t_word('o1234); t_word('o0001); t_word('o0002); t_byte('o200);
        feed(1'b0);
        chk("R8 no writes while done", wcnt, 7);
        chk("R8 done holds", int'(done), 1);

        // R9 bad checksum
        do_start(1'b0);
        build_main(1);
        feed(1'b1);
        chk("R9 bad checksum flagged", int'(cerr), 1);
        chk("R9 done with bad checksum", int'(done), 1);
        chk("R3 writes with gaps", wcnt, 7);

        // R10 overflow: write dropped, address still advances
        do_start(1'b0);
        t_clear();
        t_word('o10100);
        t_byte('o241);
        t_word('o5555);
        t_byte('o201);
        t_word('o6666);
        t_word('o7070);
        t_trailer(0);
        feed(1'b1);
        chk("R10 dropped write count", wcnt, 2);
        exp_wr("R10 address advanced past dropped word", 0, 'o00101, 'o6666);
        exp_wr("R10 following word", 1, 'o00102, 'o7070);
        chk("R10 ovf set", int'(ovf), 1);
        chk("R10 checksum still good", int'(cerr), 0);
        do_start(1'b0);
        chk("R1 start clears ovf", int'(ovf), 0);
        chk("R1 start clears done", int'(done), 0);

        // R11 start beats a frame; R6 rubout swallows 377 and field frame
        do_start(1'b1);
        t_clear();
        t_byte(0);
        t_word('o1111);
        t_byte('o377); t_byte('o377);
        t_byte('o377); t_byte('o271);
        t_word('o2222);
        t_word('o3333);
        t_trailer(0);
        feed(1'b0);
        chk("R11 write count", wcnt, 3);
        exp_wr("R11 R1 first word at zero", 0, 'o00000, 'o1111);
        exp_wr("R6 double rubout", 1, 'o00001, 'o2222);
        exp_wr("R6 dropped field frame", 2, 'o00002, 'o3333);
        chk("R9 checksum after rubouts", int'(cerr), 0);

        // R7 R10 field sweep over all eight fields
        for (int f = 0; f < 8; f++) begin
            do_start(1'b0);
            t_clear();
            t_word('o10100);
            t_byte('o201 | (f << 3));
            t_word('o5000 + f);
            t_trailer(0);
            feed(f[0]);
            if ((f << 12) < MEMW) begin
                chk("R7 field sweep count", wcnt, 1);
                exp_wr("R7 field sweep word", 0, (f << 12) | 'o100, 'o5000 + f);
                chk("R10 field sweep no ovf", int'(ovf), 0);
            end else begin
                chk("R10 field sweep dropped", wcnt, 0);
                chk("R10 field sweep ovf", int'(ovf), 1);
            end
            chk("R8 field sweep done", int'(done), 1);
        end

        // R2 R3 R5 data sweep across the address wrap
        do_start(1'b0);
        t_clear();
        t_byte('o200); t_byte(0); t_byte('o200); t_byte(0);
        t_word('o17740);
        for (int i = 0; i < 64; i++) t_word((i * 'o1237 + 'o15) & 'o7777);
        t_trailer(0);
        feed(1'b1);
        chk("R3 sweep count", wcnt, 64);
        for (int i = 0; i < 64; i++)
            exp_wr("R5 R3 sweep word", i, ('o7740 + i) & 'o7777, (i * 'o1237 + 'o15) & 'o7777);
        chk("R2 R9 sweep checksum", int'(cerr), 0);
        chk("R8 sweep done", int'(done), 1);

        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual running expected finished");
            $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
            $finish;
        end
    end

endmodule